// File: doc/BRIEF.md
# Four-Beat Burst Memory Sequencer

This block sits between a command source and a small synchronous word array. It behaves like the control front end of a burst-capable static memory. On every rising clock edge it samples a clock-enable strobe, an active-low output enable and three burst-control strobes. From these it decides whether to freeze, idle, start a new read burst, start a new write burst, or step the burst already running. A burst is two beats (single) or four beats (double) long. The two low address bits follow either an interleaved or a linear order, and the mode pin picks the order when a burst is started.

Reads are registered, so a word appears on the data output one clock after its address is loaded or stepped. The block produces a drive-enable for the shared data bus and a direction flag. It also shows the address of the most recent access and raises a busy flag while more beats of the burst remain. Writes always replace the whole word.

Top module: `bsq_top`

## Requirements
- R1: With `clk_en` low, no burst state, array word or read register changes, `cur_addr` and `busy` hold, and `dq_oe` is 0.
- R2: With `clk_en` high, `ctl_a`=1 and `ctl_b`=0 mean idle. Any burst in progress ends (`busy` is 0 afterwards), and no read data is driven after that edge.
- R3: With `clk_en` high, `ctl_a`=0 and `ctl_b`=1 load `addr_in` and read that word. The word is on `dq_o` after the edge. `dq_oe` is 1 only while `oe_n` is 0.
- R4: With `clk_en` high, `ctl_a`=0 and `ctl_b`=0 load `addr_in` and write the full `din` word there, whatever the value of `oe_n`. `dq_oe` is 0 after a write access.
- R5: `ctl_c`=1 on a load selects a two-beat burst and `ctl_c`=0 selects a four-beat burst. `busy` is 1 after each beat that still has a further beat to follow, and 0 after the last beat.
- R6: `ctl_a`=1 with `ctl_b`=1 steps to the next beat address of the running burst. It keeps the burst's direction: it reads if the burst is a read and writes `din` if it is a write. `bus_wr` is 1 for a write burst and 0 for a read burst. `addr_in` is ignored on a step.
- R7: If `ilv_mode` is 1 at the load, beat k (k = 0..3) uses low address bits equal to the start's low bits XOR k. The pin is ignored for the rest of the burst.
- R8: If `ilv_mode` is 0 at the load, beat k uses low bits equal to the start's low bits plus k, modulo 4.
- R9: Address bits above bit 1 stay equal to those of the start address for every beat of a burst.
- R10: A step command issued when no further beat remains has no effect. `cur_addr` and the array are unchanged, `busy` stays 0, and no read data is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| oe_n | input | 1 | Active-low output enable for read data |
| ctl_a | input | 1 | Burst control strobe A |
| ctl_b | input | 1 | Burst control strobe B |
| ctl_c | input | 1 | Burst length select on load (1 = two beats) |
| ilv_mode | input | 1 | Burst order on load (1 = interleaved, 0 = linear) |
| addr_in | input | ADDR_W | Start address for a load |
| din | input | DATA_W | Write data |
| dq_o | output | DATA_W | Registered read data |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| bus_wr | output | 1 | Direction of the current burst (1 = write) |
| busy | output | 1 | Further beats remain in the current burst |
| cur_addr | output | ADDR_W | Address of the most recent access |

## Verification
The bench runs bursts from starting low bits 00, 01, 10 and 11 in both orders, and toggles the mode pin during bursts. A design that does not latch the order, or that confuses XOR with addition, returns the wrong words. It also steps past the end of two-beat and four-beat bursts with fresh write data on the bus; a sequencer that wraps or keeps counting would overwrite words that later reads expose. A frozen cycle carrying a write command, and an idle command in mid-burst, are each followed by reads. These reads catch a design that lets a stalled clock write, or that resumes a burst after an idle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [2:0] {
        OP_FREEZE,
        OP_IDLE,
        OP_LOAD_RD,
        OP_LOAD_WR,
        OP_STEP
    } op_e;

    typedef struct packed {
        op_e  op;
        logic two_beat;
    } cmd_t;

    typedef struct packed {
        logic  active;
        logic  wr;
        logic  ilv;
        beat_t beat;
        beat_t last;
    } burst_t;

    function automatic cmd_t decode_cmd(input logic en, input logic a,
                                        input logic b, input logic c);
        cmd_t r;
        r.two_beat = c;
        if (!en) begin
            r.op = OP_FREEZE;
        end else begin
            case ({a, b})
                2'b10:   r.op = OP_IDLE;
                2'b01:   r.op = OP_LOAD_RD;
                2'b00:   r.op = OP_LOAD_WR;
                default: r.op = OP_STEP;
            endcase
        end
        return r;
    endfunction

    function automatic beat_t beat_low(input beat_t start, input beat_t k,
                                       input logic ilv);
        return ilv ? (start ^ k) : beat_t'(start + k);
    endfunction

endpackage

// File: rtl/bsq_decode.sv
module bsq_decode
    import bsq_pkg::*;
(
    input  logic clk_en,
    input  logic ctl_a,
    input  logic ctl_b,
    input  logic ctl_c,
    output cmd_t cmd
);
    always_comb begin
        cmd = decode_cmd(clk_en, ctl_a, ctl_b, ctl_c);
    end
endmodule

// File: rtl/bsq_seq.sv
module bsq_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_mode,
    output logic              acc_en,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              busy,
    output logic              dir_wr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    burst_t            st_q;
    logic [ADDR_W-1:0] start_q;
    beat_t             nxt_beat;
    logic              is_load;

    assign nxt_beat = beat_t'(st_q.beat + 1'b1);
    assign is_load  = (cmd.op == OP_LOAD_RD) || (cmd.op == OP_LOAD_WR);

    always_comb begin
        acc_en   = 1'b0;
        acc_wr   = 1'b0;
        acc_addr = addr_in;
        if (is_load) begin
            acc_en = 1'b1;
            acc_wr = (cmd.op == OP_LOAD_WR);
        end else if (cmd.op == OP_STEP && st_q.active) begin
            acc_en   = 1'b1;
            acc_wr   = st_q.wr;
            acc_addr = {start_q[ADDR_W-1:BEAT_W],
                        beat_low(start_q[BEAT_W-1:0], nxt_beat, st_q.ilv)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            start_q  <= '0;
            cur_addr <= '0;
        end else begin
            case (cmd.op)
                OP_LOAD_RD, OP_LOAD_WR: begin
                    st_q.active <= 1'b1;
                    st_q.wr     <= (cmd.op == OP_LOAD_WR);
                    st_q.ilv    <= ilv_mode;
                    st_q.beat   <= '0;
                    st_q.last   <= cmd.two_beat ? beat_t'(1) : beat_t'(BEATS - 1);
                    start_q     <= addr_in;
                    cur_addr    <= addr_in;
                end
                OP_STEP: begin
                    if (st_q.active) begin
                        st_q.beat   <= nxt_beat;
                        st_q.active <= (nxt_beat != st_q.last);
                        cur_addr    <= acc_addr;
                    end
                end
                OP_IDLE: st_q.active <= 1'b0;
                default: ;
            endcase
        end
    end

    assign busy   = st_q.active;
    assign dir_wr = st_q.wr;

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_FREEZE |=> $stable(cur_addr) && $stable(busy) && $stable(dir_wr)); // R1
    AST_IDLE_ENDS: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_IDLE |=> !busy); // R2
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        is_load |=> busy && cur_addr == $past(addr_in)); // R5
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_STEP && busy) |=>
            cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])); // R9
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_STEP && busy && !st_q.ilv) |=>
            cur_addr[BEAT_W-1:0] == beat_t'($past(cur_addr[BEAT_W-1:0]) + 1'b1)); // R8
    AST_ILV_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_STEP && busy && st_q.ilv) |=>
            (cur_addr[BEAT_W-1:0] ^ $past(cur_addr[BEAT_W-1:0])) ==
            ($past(st_q.beat) ^ beat_t'($past(st_q.beat) + 1'b1))); // R7
    AST_STEP_PAST_END: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_STEP && !busy) |=> $stable(cur_addr) && !busy); // R10

    if (HI_W < 0) begin : g_bad_width
        initial $error("ADDR_W too small for a four-beat burst");
    end
endmodule

// File: rtl/bsq_mem.sv
module bsq_mem #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 18,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (advance && acc_en && acc_wr) begin
            mem[acc_addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (advance) begin
            rvalid <= acc_en && !acc_wr;
            if (acc_en && !acc_wr) begin
                rdata <= mem[acc_addr];
            end
        end
    end

    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (advance && acc_en && acc_wr) |=> !rvalid); // R4
    AST_HOLD_READ: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(rvalid) && $stable(rdata)); // R1
endmodule

// File: rtl/bsq_top.sv
module bsq_top
    import bsq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 18,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              oe_n,
    input  logic              ctl_a,
    input  logic              ctl_b,
    input  logic              ctl_c,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              bus_wr,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr
);
    cmd_t              cmd;
    logic              acc_en;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic              rvalid;

    bsq_decode u_decode (
        .clk_en (clk_en),
        .ctl_a  (ctl_a),
        .ctl_b  (ctl_b),
        .ctl_c  (ctl_c),
        .cmd    (cmd)
    );

    bsq_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_in  (addr_in),
        .ilv_mode (ilv_mode),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .busy     (busy),
        .dir_wr   (bus_wr),
        .cur_addr (cur_addr)
    );

    bsq_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .advance  (cmd.op != OP_FREEZE),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .wdata    (din),
        .rdata    (dq_o),
        .rvalid   (rvalid)
    );

    // Registered read-valid gated by the live enables: the bus floats
    // whenever the clock is stopped or output enable is released.
    assign dq_oe = rvalid && !oe_n && clk_en;

    AST_IDLE_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ctl_a && !ctl_b) |=> !rvalid); // R2
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !ctl_a && ctl_b) |=> rvalid && !bus_wr); // R3
    AST_WRITE_DIR: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !ctl_a && !ctl_b) |=> bus_wr && !dq_oe); // R6
endmodule

// File: tb/bsq_top_bench.sv
module bsq_top_bench;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 18;
    localparam int AW     = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_en = 1'b0;
    logic              oe_n = 1'b1;
    logic              ctl_a = 1'b1;
    logic              ctl_b = 1'b0;
    logic              ctl_c = 1'b0;
    logic              ilv_mode = 1'b0;
    logic [AW-1:0]     addr_in = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dq_o;
    logic              dq_oe;
    logic              bus_wr;
    logic              busy;
    logic [AW-1:0]     cur_addr;

    bsq_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bsq_top (
        .clk(clk), .rst(rst), .clk_en(clk_en), .oe_n(oe_n),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c), .ilv_mode(ilv_mode),
        .addr_in(addr_in), .din(din), .dq_o(dq_o), .dq_oe(dq_oe),
        .bus_wr(bus_wr), .busy(busy), .cur_addr(cur_addr)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [AW-1:0]     addr;
        logic              busy;
        logic              oe;
        logic              wr;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference state, built from the requirements
    logic [DATA_W-1:0] bm [DEPTH];
    logic [AW-1:0]     m_start = '0;
    logic [AW-1:0]     m_addr  = '0;
    int                m_beat = 0, m_last = 0;
    bit                m_act = 0, m_wr = 0, m_ilv = 0;

    function automatic logic [DATA_W-1:0] wdat(int a, int s);
        return DATA_W'((a * 18'h1111) ^ (s * 18'h0357) ^ 18'h2A5A5);
    endfunction

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] st, int k, bit ilv);
        logic [1:0] lo;
        lo = ilv ? (st[1:0] ^ 2'(k)) : 2'(st[1:0] + 2'(k));
        return {st[AW-1:2], lo};
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic drive(bit en, bit on, bit a, bit b, bit c, bit ilv,
                         logic [AW-1:0] ad, logic [DATA_W-1:0] d, exp_t e);
        @(negedge clk);
        clk_en = en; oe_n = on; ctl_a = a; ctl_b = b; ctl_c = c;
        ilv_mode = ilv; addr_in = ad; din = d;
        q.push_back(e);
    endtask

    task automatic load(bit rd, bit two, logic [AW-1:0] a, bit on, bit ilv,
                        logic [DATA_W-1:0] d, string tag);
        exp_t e;
        e.addr = a; e.busy = 1'b1; e.wr = !rd; e.tag = tag;
        e.oe = rd && !on; e.data = bm[a];
        if (!rd) bm[a] = d;
        m_start = a; m_addr = a; m_beat = 0; m_last = two ? 1 : 3;
        m_act = 1; m_wr = !rd; m_ilv = ilv;
        drive(1, on, 1'b0, rd, two, ilv, a, d, e);
    endtask

    task automatic step(bit on, bit ilv_pin, logic [DATA_W-1:0] d, string tag);
        exp_t e;
        e.tag = tag; e.wr = m_wr; e.oe = 1'b0; e.data = '0;
        if (m_act) begin
            m_beat++;
            m_addr = beat_addr(m_start, m_beat, m_ilv);
            if (m_wr) bm[m_addr] = d;
            else begin e.oe = !on; e.data = bm[m_addr]; end
            m_act = (m_beat != m_last);
        end
        e.addr = m_addr; e.busy = m_act;
        drive(1, on, 1'b1, 1'b1, 1'b0, ilv_pin, 4'hE, d, e);
    endtask

    task automatic idle(string tag);
        exp_t e;
        m_act = 0;
        e.addr = m_addr; e.busy = 1'b0; e.oe = 1'b0; e.wr = m_wr;
        e.data = '0; e.tag = tag;
        drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h3, '0, e);
    endtask

    task automatic freeze(bit a, bit b, logic [AW-1:0] ad, logic [DATA_W-1:0] d, string tag);
        exp_t e;
        e.addr = m_addr; e.busy = m_act; e.oe = 1'b0; e.wr = m_wr;
        e.data = '0; e.tag = tag;
        drive(0, 1'b0, a, b, 1'b0, 1'b0, ad, d, e);
    endtask

    // monitor: one expected item per clock, compared a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(cur_addr == e.addr, e.tag, "cur_addr", cur_addr, e.addr);
                check(busy == e.busy, e.tag, "busy", busy, e.busy);
                check(dq_oe == e.oe, e.tag, "dq_oe", dq_oe, e.oe);
                check(bus_wr == e.wr, e.tag, "bus_wr", bus_wr, e.wr);
                if (e.oe) check(dq_o == e.data, e.tag, "dq_o", dq_o, e.data);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) bm[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cur_addr == 0, "R1 reset", "cur_addr", cur_addr, 0);
        check(busy == 0, "R1 reset", "busy", busy, 0);
        check(dq_oe == 0, "R1 reset", "dq_oe", dq_oe, 0);
        rst = 1'b0;

        // fill the array with four-beat write bursts in both orders
        load(0, 0, 4'h0, 1, 1, wdat(0, 1), "R4 R7 wr ilv 0");
        for (int k = 1; k < 4; k++) step(1, 0, wdat(k, 1), "R6 R7 wr ilv 0");
        load(0, 0, 4'h6, 0, 0, wdat(6, 1), "R4 R8 wr lin 6");
        for (int k = 1; k < 4; k++) step(0, 1, wdat(k + 6, 2), "R7 R8 wr lin 6 pin toggled");
        load(0, 0, 4'hB, 1, 1, wdat(11, 1), "R7 wr ilv B");
        for (int k = 1; k < 4; k++) step(1, 0, wdat(k + 11, 3), "R7 R9 wr ilv B");
        load(0, 0, 4'hD, 1, 0, wdat(13, 1), "R8 wr lin D");
        for (int k = 1; k < 4; k++) step(1, 0, wdat(k + 13, 4), "R8 R9 wr lin D");
        step(1, 0, wdat(99, 9), "R10 step after four beats");

        // reads in both orders
        load(1, 0, 4'h9, 0, 1, '0, "R3 R7 rd ilv 9");
        for (int k = 1; k < 4; k++) step(0, 0, '0, "R6 R7 rd ilv 9");
        load(1, 0, 4'h3, 0, 0, '0, "R3 R8 rd lin 3");
        for (int k = 1; k < 4; k++) step(0, 1, '0, "R7 R8 rd lin 3 pin toggled");
        load(1, 1, 4'h6, 0, 1, '0, "R5 rd two-beat 6");
        step(0, 0, '0, "R5 rd two-beat second");
        step(0, 0, '0, "R10 rd step past end");
        load(1, 1, 4'h2, 1, 0, '0, "R3 rd with oe_n high");
        step(0, 0, '0, "R3 rd oe_n low again");

        // clock stop mid-burst, with a write command on the strobes
        load(1, 0, 4'hE, 0, 0, '0, "R1 rd lin E");
        step(0, 0, '0, "R1 rd lin E beat1");
        freeze(1'b0, 1'b0, 4'h5, wdat(77, 7), "R1 frozen write cmd");
        freeze(1'b1, 1'b1, 4'h5, wdat(78, 7), "R1 frozen step");
        step(0, 0, '0, "R1 resume beat2");
        step(0, 0, '0, "R1 resume beat3");
        step(0, 0, '0, "R10 step past end after resume");
        load(1, 1, 4'h5, 0, 0, '0, "R1 word 5 untouched");

        // idle in mid-burst ends the burst
        load(0, 0, 4'h4, 0, 1, wdat(40, 5), "R4 wr with oe_n low");
        step(0, 1, wdat(41, 5), "R4 wr beat1");
        idle("R2 idle ends burst");
        step(0, 1, wdat(42, 5), "R2 R10 step after idle");
        load(1, 0, 4'h4, 0, 0, '0, "R2 R4 readback 4");
        for (int k = 1; k < 4; k++) step(0, 0, '0, "R2 R4 readback 4");

        // two-beat write, then a step that must not write
        load(0, 1, 4'h1, 1, 0, wdat(50, 6), "R5 wr two-beat 1");
        step(1, 0, wdat(51, 6), "R5 wr two-beat second");
        step(1, 0, wdat(52, 6), "R10 wr step past end");
        load(1, 0, 4'h0, 0, 1, '0, "R5 R10 readback 0");
        for (int k = 1; k < 4; k++) step(0, 0, '0, "R5 R10 readback 0");
        idle("R2 final idle");
        idle("R2 final idle");

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule